// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a simple synchronous request port and an external 32K x 8 asynchronous static RAM. The RAM has three active-low controls: chip select, output enable and write enable. The host raises a request strobe for one clock, together with a read/write flag, an address and write data. The controller then runs one complete memory cycle on the RAM pins. It returns read data, a one-clock done pulse and a busy flag.

The RAM has no clock, so every timing rule it imposes is given to the controller as a delay in nanoseconds. These rules are the access time, the output-enable access time, the write pulse width, the select-to-end-of-write time, the data setup time, the output float time and the minimum cycle time. A parameter gives the clock period. Each delay becomes a whole number of clocks: the delay divided by the period, rounded up, and never less than one. The data pins are modelled as an output value, an output enable and an input value, and the chip pad joins them into one bidirectional bus.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, busy and done are 0. Chip select, output enable and write enable are all high (1), and the data bus output enable is 0.
- R2: A read asserts chip select and output enable low in the same clock, with write enable high. It holds them for N_RD = max(ceil(T_ACCESS/T), ceil(T_OE/T)) clocks and registers the bus into rdata at the edge that ends that window. done is high in the clock after that edge, so done is first seen N_RD+1 clocks after the accepting edge. rdata equals the byte stored at the address.
- R3: In a write, output enable stays high (1) for the whole cycle. Write enable and chip select fall in the same clock. Write enable stays low for at least ceil(T_WPULSE/T) clocks, and chip select stays low for at least ceil(T_CSWR/T) clocks before write enable rises.
- R4: The controller drives the data bus only while write enable is low, and only from ceil(T_FLOAT/T) clocks after write enable falls. It drives for at least ceil(T_DSETUP/T) clocks before write enable rises, keeps driving for exactly one clock after that rise, and holds the driven value stable throughout.
- R5: The controller never drives the bus while output enable is low, nor within T_FLOAT after output enable rises.
- R6: Two successive falling edges of chip select are at least ceil(T_CYCLE/T) clocks apart.
- R7: busy is high from the clock after a request is accepted until the controller is idle again, and is low whenever chip select is high and no cycle is in progress. A request presented while busy is ignored: it starts no memory cycle and changes no stored byte.
- R8: done is high for exactly one clock per completed read or write.
- R9: The memory address stays stable for as long as chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, accepted only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | Cycle in progress |
| mem_addr | output | AW | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DW | Value driven onto the data bus |
| mem_dq_drv | output | 1 | Data bus output enable |
| mem_dq_in | input | DW | Value sampled from the data bus |

## Verification
The bench uses a RAM model that returns a filler byte until the access and output-enable delays, counted in clocks, have both elapsed. A controller that samples one clock early therefore reads the wrong byte, and a wrong read latency is flagged on every read. Every write is timed at the pins: the write pulse width, the select-to-end-of-write time, the data setup time, the float gap after write enable falls and the one-clock hold after write enable rises. A shortened phase or an early bus drive shows up as a timing failure. Requests are held asserted throughout busy cycles, and the bench then reads the target address back to show that no stray write or extra chip-select cycle occurred. A full sweep writes and reads back every address of a small array.

// File: rtl/sram_async_ctl.sv
module sram_async_ctl #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_CYCLE_NS    = 70,
  parameter int T_ACCESS_NS   = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_WPULSE_NS   = 45,
  parameter int T_CSWR_NS     = 60,
  parameter int T_DSETUP_NS   = 30,
  parameter int T_FLOAT_NS    = 30,
  parameter int AW            = 15,
  parameter int DW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_drv,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int clks(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_CYC  = clks(T_CYCLE_NS);
  localparam int N_RD   = imax(clks(T_ACCESS_NS), clks(T_OE_NS));
  localparam int N_FLT  = clks(T_FLOAT_NS);
  localparam int N_WLOW = imax(imax(clks(T_WPULSE_NS), clks(T_CSWR_NS)),
                               N_FLT + clks(T_DSETUP_NS));
  localparam int N_WDAT = N_WLOW - N_FLT;
  localparam int N_RREC = imax(imax(N_FLT, N_CYC - N_RD), 1);
  localparam int N_WREC = imax(N_CYC - N_WLOW, 1);
  localparam int N_MAX  = imax(imax(N_RD, N_WLOW), imax(N_RREC, N_WREC));
  localparam int CW     = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RACC, S_WFLT, S_WDAT, S_REC} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;

  assign busy       = (st != S_IDLE);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      addr_q     <= '0;
      wd_q       <= '0;
      rdata      <= '0;
      done       <= 1'b0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_drv <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          addr_q   <= req_addr;
          mem_cs_n <= 1'b0;
          if (req_wr) begin
            wd_q     <= req_wdata;
            mem_we_n <= 1'b0;
            cnt      <= CW'(N_FLT - 1);
            st       <= S_WFLT;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CW'(N_RD - 1);
            st       <= S_RACC;
          end
        end
        S_RACC: if (cnt == '0) begin
          rdata    <= mem_dq_in;
          done     <= 1'b1;
          mem_cs_n <= 1'b1;
          mem_oe_n <= 1'b1;
          cnt      <= CW'(N_RREC - 1);
          st       <= S_REC;
        end else cnt <= cnt - 1'b1;
        S_WFLT: if (cnt == '0) begin
          mem_dq_drv <= 1'b1;
          cnt        <= CW'(N_WDAT - 1);
          st         <= S_WDAT;
        end else cnt <= cnt - 1'b1;
        S_WDAT: if (cnt == '0) begin
          mem_we_n <= 1'b1;
          mem_cs_n <= 1'b1;
          done     <= 1'b1;
          cnt      <= CW'(N_WREC - 1);
          st       <= S_REC;
        end else cnt <= cnt - 1'b1;
        S_REC: begin
          mem_dq_drv <= 1'b0;
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R3
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_drv); // R5
  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_drv) |-> !mem_we_n); // R4
  AST_DRIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_drv && $past(mem_dq_drv)) |-> $stable(mem_dq_out)); // R4
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R9
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_drv)); // R7

endmodule

// File: tb/sram_async_ctl_test.sv
`timescale 1ns/1ps
module sram_async_ctl_test;
  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam int DW = 8;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_RD  = (cdiv(70) > cdiv(35)) ? cdiv(70) : cdiv(35);
  localparam int E_CYC = cdiv(70);

  logic clk = 0, rst_n = 0;
  logic req = 0, req_wr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rdata, mem_dq_out, mem_dq_in;
  logic done, busy, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_drv;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_err = 0;
  logic [7:0] ram [256];

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctl #(.CLK_PERIOD_NS(CLK_NS), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rdata(rdata), .done(done), .busy(busy),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_drv(mem_dq_drv), .mem_dq_in(mem_dq_in));

  function automatic logic [7:0] pat(input logic [7:0] a);
    return (a * 8'd29 + 8'd7) ^ {a[3:0], a[7:4]};
  endfunction

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  // pin monitor and RAM model, sampled at the falling edge
  int cs_low = 0, oe_low = 0, we_low = 0, drv_cnt = 0, oe_high = 100, a_stab = 0;
  int cs_gap = 0, we_falls = 0;
  bit gap_valid = 0, oe_bad = 0, rel_chk = 0, prv_cs = 1, prv_we = 1, prv_drv = 0;
  logic [7:0] prv_out = '0, prv_addr = '0;

  initial mem_dq_in = 8'h5A;

  always @(negedge clk) begin
    if (!rst_n) begin
      cs_low = 0; oe_low = 0; we_low = 0; drv_cnt = 0; oe_high = 100; a_stab = 0;
      gap_valid = 0; prv_cs = 1; prv_we = 1; prv_drv = 0; rel_chk = 0;
    end else begin
      if (rel_chk) begin
        check(!mem_dq_drv, "R4 drive released one clock after write end", mem_dq_drv, 0);
        rel_chk = 0;
      end
      if (!mem_cs_n && prv_cs) begin
        if (gap_valid) check(cs_gap >= E_CYC, "R6 select-to-select clocks", cs_gap, E_CYC);
        cs_gap = 0; gap_valid = 1;
      end
      cs_gap++;
      if (!mem_we_n && prv_we) we_falls++;
      if (mem_we_n && !prv_we) begin
        check(we_low * CLK_NS >= 45, "R3 write pulse ns", we_low * CLK_NS, 45);
        check(cs_low * CLK_NS >= 60, "R3 select to write end ns", cs_low * CLK_NS, 60);
        check(drv_cnt * CLK_NS >= 30, "R4 data setup ns", drv_cnt * CLK_NS, 30);
        check(!oe_bad, "R3 output enable high during write", oe_bad, 0);
        check(mem_dq_drv, "R4 drive held after write end", mem_dq_drv, 1);
        ram[prv_addr] = prv_out;
        rel_chk = 1; oe_bad = 0;
      end
      if (mem_dq_drv && !prv_drv) begin
        check(!mem_we_n, "R4 drive only with write enable low", mem_we_n, 0);
        check((we_low) * CLK_NS >= 30, "R4 float gap after write enable fall ns", we_low * CLK_NS, 30);
        check((oe_high) * CLK_NS >= 30, "R5 float gap after output enable rise ns", oe_high * CLK_NS, 30);
      end
      if (mem_dq_drv && !mem_oe_n) check(0, "R5 drive during read", 1, 0);
      if (mem_dq_drv && prv_drv && mem_dq_out != prv_out)
        check(0, "R4 driven data stable", mem_dq_out, prv_out);
      if (!mem_we_n && !mem_oe_n) oe_bad = 1;
      cs_low  = !mem_cs_n ? cs_low + 1 : 0;
      oe_low  = !mem_oe_n ? oe_low + 1 : 0;
      we_low  = !mem_we_n ? we_low + 1 : 0;
      drv_cnt = (mem_dq_drv && !mem_we_n) ? drv_cnt + 1 : (!mem_we_n ? drv_cnt : 0);
      oe_high = mem_oe_n ? ((oe_high < 100) ? oe_high + 1 : 100) : 0;
      a_stab  = (mem_addr == prv_addr) ? a_stab + 1 : 1;
      if (!mem_cs_n && !mem_oe_n && mem_we_n && cs_low * CLK_NS >= 70 &&
          oe_low * CLK_NS >= 35 && a_stab * CLK_NS >= 70)
        mem_dq_in = ram[mem_addr];
      else
        mem_dq_in = 8'h5A;
      prv_cs = mem_cs_n; prv_we = mem_we_n; prv_drv = mem_dq_drv;
      prv_out = mem_dq_out; prv_addr = mem_addr;
    end
  end

  task automatic do_op(input bit w, input logic [7:0] a, input logic [7:0] d,
                       input bit spam, output logic [7:0] rd, output int lat);
    @(negedge clk);
    req = 1; req_wr = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    check(busy, "R7 busy after accept", busy, 1);
    if (spam) begin
      req_wr = 1; req_addr = a ^ 8'h55; req_wdata = ~d;
    end else req = 0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    req = 0;
    rd = rdata;
    @(negedge clk);
    check(!done, "R8 done lasts one clock", done, 0);
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(200000 * CLK_NS);
    check(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lat, wf;
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
    check(mem_cs_n && mem_oe_n && mem_we_n, "R1 reset strobes high",
          {mem_cs_n, mem_oe_n, mem_we_n}, 7);
    check(!mem_dq_drv, "R1 reset bus released", mem_dq_drv, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int a = 0; a < 256; a++) begin
      do_op(1, 8'(a), pat(8'(a)), 0, rd, lat);
      check(ram[a] == pat(8'(a)), "R3 byte stored", ram[a], pat(8'(a)));
    end

    for (int a = 0; a < 256; a++) begin
      do_op(0, 8'(a), 8'h00, 0, rd, lat);
      check(rd == pat(8'(a)), "R2 read data", rd, pat(8'(a)));
      check(lat == E_RD + 1, "R2 read latency clocks", lat, E_RD + 1);
    end

    // requests held during busy must be ignored
    wf = we_falls;
    do_op(0, 8'h10, 8'h00, 1, rd, lat);
    check(rd == pat(8'h10), "R7 read under held request", rd, pat(8'h10));
    check(we_falls == wf, "R7 no write started while busy", we_falls - wf, 0);
    do_op(0, 8'h10 ^ 8'h55, 8'h00, 0, rd, lat);
    check(rd == pat(8'h10 ^ 8'h55), "R7 ignored write left byte", rd, pat(8'h10 ^ 8'h55));

    wf = we_falls;
    do_op(1, 8'h22, 8'hC3, 1, rd, lat);
    check(we_falls == wf + 1, "R7 single write cycle under held request", we_falls - wf, 1);
    do_op(0, 8'h22 ^ 8'h55, 8'h00, 0, rd, lat);
    check(rd == pat(8'h22 ^ 8'h55), "R7 ignored write left byte", rd, pat(8'h22 ^ 8'h55));
    do_op(0, 8'h22, 8'h00, 0, rd, lat);
    check(rd == 8'hC3, "R2 read after overwrite", rd, 8'hC3);

    // alternating write/read on the bus turnaround
    for (int k = 0; k < 16; k++) begin
      do_op(1, 8'(k * 17), 8'(k * 9 + 1), 0, rd, lat);
      do_op(0, 8'(k * 17), 8'h00, 0, rd, lat);
      check(rd == 8'(k * 9 + 1), "R2 read right after write", rd, 8'(k * 9 + 1));
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule